// File: doc/BRIEF.md
# Five-Port Mesh Router with Per-Flit Arbitration

This block is one router tile of a 4x4 two-dimensional mesh. It has five ports: local, north, south, east and west. Each port has an input side and an output side, and each side uses a valid/ready handshake. No channel or circuit is reserved for a flow. Every flit carries its own destination and priority, and the router routes and arbitrates each flit by itself. Flits from different flows can therefore follow one another on the same output link, one flit at a time.

A flit is `{dest[3:0], prio[1:0], payload}`, with the most significant bit first. In the destination field, bits [1:0] are the X coordinate and bits [3:2] are the Y coordinate. Two parameters set the router's own X and Y coordinates.

Each input has two queues, and the MSB of the priority tag chooses between them. An accepted flit waits in its queue. Its header is decoded at the queue head. An arbiter for each output then picks one head, and that flit goes through the crossbar into the output register. The output register keeps its flit until downstream takes it.

Top module: `mesh_router`

## Requirements
- R1: After synchronous reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A flit whose destination X is greater than the router's X leaves on east (port 3). A flit whose destination X is smaller leaves on west (port 4). The Y coordinate plays no part in this choice.
- R3: When the X coordinates match, a flit with a greater destination Y leaves on north (port 1), and a flit with a smaller destination Y leaves on south (port 2).
- R4: When both coordinates match, the flit leaves on local (port 0).
- R5: Take a flit accepted at clock edge k whose output register is empty and which meets no competition. Its `out_valid` is still 0 after edge k and becomes 1 after edge k+1.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output holds both its flit and its valid. No flit is ever lost or delivered twice.
- R7: Each input has two queues of QDEPTH (default 4) flits. Priority MSB 0 selects the low queue and MSB 1 selects the high queue. `in_ready` is 0 exactly when the queue chosen by the offered flit is full, so the other class is still accepted.
- R8: When several queue heads compete for a free output, the head with the numerically highest 2-bit priority is sent first.
- R9: Heads of equal priority share an output in round-robin order. Two inputs that compete continuously therefore alternate, flit by flit, on that link.
- R10: Flits from one input with the same priority MSB and the same output leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per input port: a flit is offered (bit index = port number) |
| in_ready | output | 5 | Per input port: the offered flit will be accepted at the next edge |
| in_flit | input | 5*(6+PAYLOAD_W) | Offered flits; port p uses slice [p*FW +: FW] |
| out_valid | output | 5 | Per output port: the output register holds a flit |
| out_ready | input | 5 | Per output port: downstream takes the flit at the next edge |
| out_flit | output | 5*(6+PAYLOAD_W) | Output flits, sliced the same way as in_flit |

## Verification
`in_ready` is combinational from the queue fill and from the offered flit's priority MSB, so the bench reads it in the same cycle, before the edge that would accept the flit. A flit accepted at edge k may first appear at an output after edge k+1. The latency check therefore looks at the output once after edge k, where it must still be empty, and once after edge k+1, where it must be present. All inputs are driven on the falling edge. Ports are sampled 2 ns before the next rising edge, and a transfer is counted when valid and ready are both seen at that moment. Random traffic with random downstream stalls is checked flit by flit: each flit must reach the output that its coordinates select, at most once and in queue order. At the end the queues are drained, and the bench confirms that no accepted flit is still missing.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORT  = 5;
  localparam int DEST_W = 4;
  localparam int PRIO_W = 2;
  localparam int HDR_W  = DEST_W + PRIO_W;
  localparam int NCLS   = 2;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  // X is resolved before Y; local only when both coordinates match.
  function automatic port_e route_of(input logic [DEST_W-1:0] dest,
                                     input logic [1:0] mx,
                                     input logic [1:0] my);
    if (dest[1:0] > mx)      return PORT_EAST;
    else if (dest[1:0] < mx) return PORT_WEST;
    else if (dest[3:2] > my) return PORT_NORTH;
    else if (dest[3:2] < my) return PORT_SOUTH;
    else                     return PORT_LOCAL;
  endfunction
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  // Storage has no reset so that it maps onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (rd_en) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));

  // R7: the queue never takes a flit while it is full
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  // R7: a pop needs a stored flit
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  // R7: the fill level stays within the depth
  p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/hdr_decode.sv
module hdr_decode
  import router_pkg::*;
#(
  parameter int MY_X = 1,
  parameter int MY_Y = 1
) (
  input  logic [HDR_W-1:0]  hdr,
  output logic [NPORT-1:0]  port_req,
  output logic [PRIO_W-1:0] prio
);
  localparam logic [1:0] MX = 2'(MY_X);
  localparam logic [1:0] MY = 2'(MY_Y);

  port_e dir;

  assign dir      = route_of(hdr[HDR_W-1 -: DEST_W], MX, MY);
  assign prio     = hdr[PRIO_W-1:0];
  assign port_req = NPORT'(1) << dir;
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter
  import router_pkg::*;
#(
  parameter int N = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prio,
  output logic [N-1:0]        gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0]     ptr, gidx;
  logic [PRIO_W-1:0] maxp;
  logic              found;

  always_comb begin
    maxp = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k] && prio[k*PRIO_W +: PRIO_W] > maxp) maxp = prio[k*PRIO_W +: PRIO_W];
    end
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (en && !found && req[j] && prio[j*PRIO_W +: PRIO_W] == maxp) begin
        gnt[j] = 1'b1;
        gidx   = IW'(j);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (found) ptr <= (gidx == IW'(N-1)) ? '0 : gidx + IW'(1);
  end

  // R9: at most one queue head wins an output per cycle
  p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  // R8: a grant only goes to a requesting head
  p_grant_req_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  // R8: a free output with a waiting head is never left idle
  p_no_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (en && (|req)) |-> (|gnt));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int MY_X      = 1,
  parameter int MY_Y      = 1,
  parameter int PAYLOAD_W = 16,
  parameter int QDEPTH    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NPORT-1:0]                     in_valid,
  output logic [NPORT-1:0]                     in_ready,
  input  logic [NPORT*(HDR_W+PAYLOAD_W)-1:0]   in_flit,
  output logic [NPORT-1:0]                     out_valid,
  input  logic [NPORT-1:0]                     out_ready,
  output logic [NPORT*(HDR_W+PAYLOAD_W)-1:0]   out_flit
);
  localparam int FW = HDR_W + PAYLOAD_W;
  localparam int NQ = NPORT * NCLS;
  localparam logic [1:0] MX = 2'(MY_X);
  localparam logic [1:0] MY = 2'(MY_Y);

  logic [FW-1:0]     q_head  [NQ];
  logic [NPORT-1:0]  dec_req [NQ];
  logic [NQ-1:0]     q_empty, q_full, q_wr, q_rd;
  logic [NQ*PRIO_W-1:0] q_prio;
  logic [NQ-1:0]     gnt     [NPORT];
  logic [FW-1:0]     obuf    [NPORT];
  logic              ov      [NPORT];

  // Input buffering and header parsing: two queues per input, by priority MSB.
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic cls;
    assign cls = in_flit[i*FW + FW - DEST_W - 1];
    assign in_ready[i] = cls ? !q_full[i*NCLS + 1] : !q_full[i*NCLS];

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      localparam int Q = i*NCLS + c;
      assign q_wr[Q] = in_valid[i] && in_ready[i] && (int'(cls) == c);

      flit_fifo #(.W(FW), .DEPTH(QDEPTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (q_wr[Q]),
        .wr_data(in_flit[i*FW +: FW]),
        .rd_en  (q_rd[Q]),
        .rd_data(q_head[Q]),
        .empty  (q_empty[Q]),
        .full   (q_full[Q])
      );

      hdr_decode #(.MY_X(MY_X), .MY_Y(MY_Y)) u_dec (
        .hdr     (q_head[Q][FW-1 -: HDR_W]),
        .port_req(dec_req[Q]),
        .prio    (q_prio[Q*PRIO_W +: PRIO_W])
      );
    end
  end

  // A head leaves its queue when any output grants it.
  always_comb begin
    q_rd = '0;
    for (int o = 0; o < NPORT; o++) q_rd = q_rd | gnt[o];
  end

  // Scheduling, switching and output buffering per output port.
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [NQ-1:0] req_o;
    logic [FW-1:0] xbar;
    logic          slot_free;

    always_comb begin
      for (int q = 0; q < NQ; q++) req_o[q] = !q_empty[q] && dec_req[q][o];
    end

    assign slot_free = !ov[o] || out_ready[o];

    prio_rr_arbiter #(.N(NQ)) u_arb (
      .clk (clk),
      .rst (rst),
      .en  (slot_free),
      .req (req_o),
      .prio(q_prio),
      .gnt (gnt[o])
    );

    always_comb begin
      xbar = '0;
      for (int q = 0; q < NQ; q++) begin
        if (gnt[o][q]) xbar = xbar | q_head[q];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                ov[o] <= 1'b0;
      else if (|gnt[o])       ov[o] <= 1'b1;
      else if (out_ready[o])  ov[o] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (|gnt[o]) obuf[o] <= xbar;
    end

    assign out_valid[o]          = ov[o];
    assign out_flit[o*FW +: FW]  = obuf[o];

    // R6: a stalled output keeps its flit and its valid
    p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
      (ov[o] && !out_ready[o]) |=> (ov[o] && $stable(obuf[o])));
    // R2 (with R3, R4): a flit only appears on the port its coordinates select
    p_route_port_r2: assert property (@(posedge clk) disable iff (rst)
      ov[o] |-> (route_of(obuf[o][FW-1 -: DEST_W], MX, MY) == 3'(o)));
  end
endmodule

// File: tb/test_mesh_router.sv
module test_mesh_router;
  localparam int NP = 5;
  localparam int PW = 16;
  localparam int FW = 6 + PW;
  localparam int MX = 1;
  localparam int MY = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    in_valid = '0;
  logic [NP-1:0]    in_ready;
  logic [NP*FW-1:0] in_flit  = '0;
  logic [NP-1:0]    out_valid;
  logic [NP-1:0]    out_ready = '0;
  logic [NP*FW-1:0] out_flit;

  always #4 clk = ~clk;

  mesh_router #(.MY_X(MX), .MY_Y(MY), .PAYLOAD_W(PW), .QDEPTH(4)) i_mesh_router (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [FW-1:0] drv_f [NP];
  bit [NP-1:0] drv_v = '0, drv_rdy = '1, acc, ov_s, ir_s;
  logic [NP*FW-1:0] of_s;
  int seqc [NP];
  int exp_port [int];
  string exp_tag [int];
  int last_seq [NP][2][NP];
  int east_log [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int exp_dir(input logic [3:0] d);
    int dx = int'(d[1:0]);
    int dy = int'(d[3:2]);
    if (dx != MX) return (dx > MX) ? 3 : 4;
    if (dy != MY) return (dy > MY) ? 1 : 2;
    return 0;
  endfunction

  function automatic string dir_req(input logic [3:0] d);
    if (int'(d[1:0]) != MX) return "R2";
    if (int'(d[3:2]) != MY) return "R3";
    return "R4";
  endfunction

  function automatic logic [FW-1:0] mk(input logic [3:0] dest, input logic [1:0] pr, input int src);
    logic [FW-1:0] f;
    f = {dest, pr, 3'(src), 13'(seqc[src])};
    seqc[src]++;
    return f;
  endfunction

  task automatic on_recv(input int o, input logic [FW-1:0] f);
    int id  = int'(f[PW-1:0]);
    int src = int'(f[15:13]);
    int sq  = int'(f[12:0]);
    int cl  = int'(f[FW-5]);
    if (!exp_port.exists(id)) begin
      chk(1'b0, "R6", "flit not pending (lost id or duplicate)", id, -1);
      return;
    end
    chk(exp_port[id] == o, exp_tag[id], "output port for flit", o, exp_port[id]);
    // R10: queue order per input, class and output
    chk(sq > last_seq[src][cl][o], "R10", "sequence order", sq, last_seq[src][cl][o] + 1);
    last_seq[src][cl][o] = sq;
    exp_port.delete(id);
    exp_tag.delete(id);
    if (o == 3) east_log.push_back(id);
  endtask

  // One clock: drive on the falling edge, sample 2 ns before the rising edge.
  task automatic cycle();
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = drv_v[i];
      in_flit[i*FW +: FW] = drv_f[i];
    end
    out_ready = drv_rdy;
    #2;
    ov_s = out_valid;
    ir_s = in_ready;
    of_s = out_flit;
    for (int i = 0; i < NP; i++) begin
      acc[i] = drv_v[i] && in_ready[i];
      if (acc[i]) begin
        int id = int'(drv_f[i][PW-1:0]);
        exp_port[id] = exp_dir(drv_f[i][FW-1 -: 4]);
        exp_tag[id]  = dir_req(drv_f[i][FW-1 -: 4]);
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (out_valid[o] && out_ready[o]) on_recv(o, out_flit[o*FW +: FW]);
    end
    for (int i = 0; i < NP; i++) if (acc[i]) drv_v[i] = 1'b0;
  endtask

  task automatic drain();
    drv_v = '0;
    drv_rdy = '1;
    for (int k = 0; k < 200 && exp_port.num() != 0; k++) cycle();
    chk(exp_port.num() == 0, "R6", "flits still missing after drain", exp_port.num(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NP; i++) begin
      seqc[i] = 0;
      drv_f[i] = '0;
      for (int c = 0; c < 2; c++) for (int o = 0; o < NP; o++) last_seq[i][c][o] = -1;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cycle();
    chk(ov_s == 5'h00, "R1", "out_valid after reset", ov_s, 0);
    chk(ir_s == 5'h1f, "R1", "in_ready after reset", ir_s, 31);

    // R5: latency from acceptance to output
    begin
      logic [FW-1:0] f;
      f = mk(4'b0011, 2'd0, 0);
      drv_f[0] = f; drv_v[0] = 1'b1;
      cycle();
      chk(acc[0], "R5", "flit accepted", acc[0], 1);
      cycle();
      chk(ov_s[3] == 1'b0, "R5", "east valid one edge after accept", ov_s[3], 0);
      cycle();
      chk(ov_s[3] == 1'b1, "R5", "east valid two edges after accept", ov_s[3], 1);
      chk(of_s[3*FW +: FW] == f, "R5", "east flit contents", of_s[3*FW +: FW], f);
      drain();
    end

    // R2 R3 R4: every destination from the local input
    for (int d = 0; d < 16; d++) begin
      drv_f[0] = mk(4'(d), 2'(d), 0); drv_v[0] = 1'b1;
      for (int k = 0; k < 10 && drv_v[0]; k++) cycle();
      drain();
    end

    // R7: low queue fills behind a stalled east port, high class still enters
    begin
      int n_acc = 0;
      bit rej = 1'b0;
      drv_rdy = 5'b10111;
      for (int k = 0; k < 20 && !rej; k++) begin
        if (!drv_v[0]) begin drv_f[0] = mk(4'b0110, 2'd0, 0); drv_v[0] = 1'b1; end
        cycle();
        if (acc[0]) n_acc++; else rej = 1'b1;
      end
      chk(n_acc == 5, "R7", "low-class flits accepted before ready drops", n_acc, 5);
      chk(ir_s[0] == 1'b0, "R7", "in_ready with full low queue", ir_s[0], 0);
      drv_f[0] = mk(4'b0110, 2'd2, 0); drv_v[0] = 1'b1;
      cycle();
      chk(acc[0] == 1'b1, "R7", "high-class flit accepted while low queue full", acc[0], 1);
      drain();
    end

    // R8: highest priority wins the east link
    begin
      int ida, idb, idc;
      east_log.delete();
      drv_rdy = 5'b10111;
      drv_f[4] = mk(4'b0111, 2'd0, 4); drv_v[4] = 1'b1; ida = int'(drv_f[4][PW-1:0]);
      cycle();
      drv_f[1] = mk(4'b0010, 2'd1, 1); drv_v[1] = 1'b1; idb = int'(drv_f[1][PW-1:0]);
      drv_f[2] = mk(4'b1110, 2'd3, 2); drv_v[2] = 1'b1; idc = int'(drv_f[2][PW-1:0]);
      repeat (4) cycle();
      drain();
      chk(east_log.size() == 3, "R8", "east flit count", east_log.size(), 3);
      if (east_log.size() == 3) begin
        chk(east_log[0] == ida, "R8", "first east flit", east_log[0], ida);
        chk(east_log[1] == idc, "R8", "priority 3 before priority 1", east_log[1], idc);
        chk(east_log[2] == idb, "R8", "priority 1 last", east_log[2], idb);
      end
    end

    // R9: equal priority from north and south alternates on east
    begin
      int nsent [NP];
      east_log.delete();
      drv_rdy = 5'b10111;
      drv_f[4] = mk(4'b0011, 2'd2, 4); drv_v[4] = 1'b1;
      cycle();
      nsent[1] = 0; nsent[2] = 0;
      for (int k = 0; k < 20 && (nsent[1] < 2 || nsent[2] < 2 || drv_v[1] || drv_v[2]); k++) begin
        for (int i = 1; i <= 2; i++) begin
          if (!drv_v[i] && nsent[i] < 2) begin
            drv_f[i] = mk(4'b0011, 2'd2, i); drv_v[i] = 1'b1; nsent[i]++;
          end
        end
        cycle();
      end
      repeat (2) cycle();
      drain();
      chk(east_log.size() == 5, "R9", "east flit count", east_log.size(), 5);
      if (east_log.size() == 5) begin
        for (int k = 1; k < 4; k++) begin
          chk((east_log[k] >> 13) != (east_log[k+1] >> 13), "R9", "sources alternate",
              east_log[k+1] >> 13, 3 - (east_log[k] >> 13));
        end
      end
    end

    // Random traffic with random stalls: R2 R3 R4 R6 R10 per flit
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int i = 0; i < NP; i++) begin
        if (!drv_v[i] && ($urandom % 2) == 0) begin
          drv_f[i] = mk(4'($urandom % 16), 2'($urandom % 4), i);
          drv_v[i] = 1'b1;
        end
      end
      for (int o = 0; o < NP; o++) drv_rdy[o] = (($urandom % 10) < 7);
      cycle();
    end
    drain();

    summary();
    $finish;
  end
endmodule